// File: doc/BRIEF.md
# Two-Region Flash Erase Range Walker

This block turns one erase request for a 32-bit-wide NOR flash array into a series of single-block erase commands. The array has a non-uniform layout: a low region of small parameter blocks followed by a region of large main blocks. A request gives a start byte address and a byte length. The walker first checks that the range lies inside the device. It then checks that each end of the range sits on a block boundary of the region that contains that end.

A request that passes the checks is walked one block at a time. The walker asks a downstream command sequencer to erase one block and waits for the acknowledge. It then advances the address by the block size of the region it is in, and switches to the large block size once it reaches the end of the small-block region. A completion pulse carries an outcome code: success, an invalid request, or a device failure. A device failure ends the walk at once.

With default parameters the small region holds 8 blocks of 16 KiB at offset 0. The large region holds 31 blocks of 128 KiB starting at byte 0x20000. The device size is 0x400000 bytes.

Top module: `erase_range_walker`

## Requirements
- R1: A request whose start plus length exceeds the device size (0x400000 by default) completes in the cycle after acceptance with status 1 (invalid) and issues no block erase.
- R2: The start address is checked against the block size of the region containing it. That region is the large region when start ≥ 0x20000, otherwise the small one. A start that is not a multiple of that size completes with status 1 and issues no erase.
- R3: The end address (start plus length) is checked against the region containing it, chosen by the same rule, so an end exactly at 0x20000 counts as large-region. A misaligned end completes with status 1 and issues no erase.
- R4: A zero-length request that passes R1 to R3 completes in the cycle after acceptance with status 0 and issues no erase.
- R5: A valid non-empty request raises erase_req in the cycle after acceptance with erase_addr equal to the start. erase_req and erase_addr stay unchanged until erase_ack, so only one block erase is outstanding.
- R6: After an acknowledged block without failure, erase_addr advances by 0x4000 while below 0x20000 and by 0x20000 from there on. The step switches to the large size when the address reaches 0x20000 within a single request.
- R7: An acknowledge with erase_fail high drops erase_req in the next cycle and completes with status 2 (I/O failure). No further block is issued.
- R8: Once the blocks covering the whole range are acknowledged without failure, erase_req drops and the block completes with status 0 in the cycle after the last acknowledge. It issues exactly one erase per block in the range.
- R9: req_ready is high only while no request is being walked. req_valid while req_ready is low is ignored.
- R10: cmpl_valid is a single-cycle pulse. cmpl_status is only 0, 1 or 2 when cmpl_valid is high.
- R11: During reset req_ready is 1 and erase_req and cmpl_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase request present |
| req_start | input | ADDR_W | Request start byte address |
| req_len | input | ADDR_W | Request length in bytes |
| req_ready | output | 1 | Walker idle, request accepted when req_valid is high |
| erase_req | output | 1 | Block erase command to the sequencer |
| erase_addr | output | ADDR_W | Byte address of the block to erase |
| erase_ack | input | 1 | Sequencer finished the current block (one-cycle pulse) |
| erase_fail | input | 1 | Block erase failed, qualified by erase_ack |
| cmpl_valid | output | 1 | Request completion pulse |
| cmpl_status | output | 2 | 0 success, 1 invalid request, 2 I/O failure |

## Verification
Valid walks are tried in three kinds of range: some stay in the small region, one stays in the large region, and one starts among the small blocks and ends among the large ones. Comparing their address sequences against the model shows whether the step size follows the region of the current address and switches at the right block. Rejected requests are chosen so that each fails exactly one test: the range limit, the start alignment or the end alignment. Each is paired with a neighbour that passes, which separates the region picked for each endpoint, especially an end landing exactly on the region boundary. A walk with an injected failure in its second block, and a walk hit by req_valid while busy, show the early stop and the blocking of new requests. Acknowledge latencies of zero to three cycles show that the address only moves on an acknowledge.

// File: rtl/erase_walk_pkg.sv
package erase_walk_pkg;

  typedef enum logic [1:0] {
    CMPL_OK    = 2'd0,
    CMPL_INVAL = 2'd1,
    CMPL_IO    = 2'd2
  } cmpl_e;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_BUSY = 1'b1
  } walk_st_e;

endpackage

// File: rtl/erase_region_lookup.sv
// Decides which erase region an address falls in and whether it sits on a
// block boundary of that region. Block sizes must be powers of two.
module erase_region_lookup #(
  parameter int unsigned W      = 25,
  parameter int unsigned R0_BLK = 16384,
  parameter int unsigned R0_CNT = 8,
  parameter int unsigned R1_BLK = 131072
) (
  input  logic [W-1:0] addr_i,
  output logic         region_o,
  output logic         aligned_o
);
  localparam logic [W-1:0] R1_OFF_V = W'(R0_BLK * R0_CNT);
  localparam logic [W-1:0] MASK0    = W'(R0_BLK - 1);
  localparam logic [W-1:0] MASK1    = W'(R1_BLK - 1);

  logic [W-1:0] mask;

  always_comb begin
    region_o  = (addr_i >= R1_OFF_V);
    mask      = region_o ? MASK1 : MASK0;
    aligned_o = ((addr_i & mask) == '0);
  end
endmodule

// File: rtl/erase_geom_check.sv
// Validates a request against the device size and the block alignment of
// the region holding each endpoint.
module erase_geom_check #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned R0_BLK = 16384,
  parameter int unsigned R0_CNT = 8,
  parameter int unsigned R1_BLK = 131072,
  parameter int unsigned R1_CNT = 31
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] len_i,
  output logic              ok_o,
  output logic              zero_o,
  output logic              start_region_o
);
  localparam int unsigned SUM_W = ADDR_W + 1;
  localparam logic [SUM_W-1:0] TOTAL_V = SUM_W'(R0_BLK * R0_CNT + R1_BLK * R1_CNT);

  logic [SUM_W-1:0] point [2];
  logic [1:0]       region;
  logic [1:0]       aligned;
  logic             in_range;

  assign point[0] = {1'b0, start_i};
  assign point[1] = {1'b0, start_i} + {1'b0, len_i};

  for (genvar e = 0; e < 2; e++) begin : g_end
    erase_region_lookup #(
      .W(SUM_W), .R0_BLK(R0_BLK), .R0_CNT(R0_CNT), .R1_BLK(R1_BLK)
    ) u_lookup (
      .addr_i   (point[e]),
      .region_o (region[e]),
      .aligned_o(aligned[e])
    );
  end

  always_comb begin
    in_range       = (point[1] <= TOTAL_V);
    ok_o           = in_range && aligned[0] && aligned[1];
    zero_o         = (len_i == '0);
    start_region_o = region[0];
  end
endmodule

// File: rtl/erase_addr_walker.sv
// Holds the current block address, the bytes still to erase and the region
// in force; steps by the current region's block size.
module erase_addr_walker #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned R0_BLK = 16384,
  parameter int unsigned R0_CNT = 8,
  parameter int unsigned R1_BLK = 131072
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              load_en_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [ADDR_W-1:0] load_len_i,
  input  logic              load_region_i,
  input  logic              step_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] STEP0    = ADDR_W'(R0_BLK);
  localparam logic [ADDR_W-1:0] STEP1    = ADDR_W'(R1_BLK);
  localparam logic [ADDR_W-1:0] R1_OFF_V = ADDR_W'(R0_BLK * R0_CNT);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] rem_q, rem_d;
  logic              region_q, region_d;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] addr_inc;
  logic              upd_en;

  always_comb begin
    step     = region_q ? STEP1 : STEP0;
    addr_inc = addr_q + step;
    upd_en   = load_en_i | step_en_i;
    addr_d   = addr_q;
    rem_d    = rem_q;
    region_d = region_q;
    if (load_en_i) begin
      addr_d   = load_addr_i;
      rem_d    = load_len_i;
      region_d = load_region_i;
    end else if (step_en_i) begin
      addr_d   = addr_inc;
      rem_d    = rem_q - step;
      region_d = region_q | (addr_inc == R1_OFF_V);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      rem_q    <= '0;
      region_q <= 1'b0;
    end else if (upd_en) begin
      addr_q   <= addr_d;
      rem_q    <= rem_d;
      region_q <= region_d;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (rem_q == step);

  // R6: the tracked region always matches the address being erased
  p_region_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (region_q == (addr_q >= R1_OFF_V)));

  // R2: every issued block address is aligned to its region's block size
  p_blk_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> ((addr_q & (step - ADDR_W'(1))) == '0));
endmodule

// File: rtl/erase_range_walker.sv
module erase_range_walker
  import erase_walk_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned R0_BLK = 16384,
  parameter int unsigned R0_CNT = 8,
  parameter int unsigned R1_BLK = 131072,
  parameter int unsigned R1_CNT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_len,
  output logic              req_ready,
  output logic              erase_req,
  output logic [ADDR_W-1:0] erase_addr,
  input  logic              erase_ack,
  input  logic              erase_fail,
  output logic              cmpl_valid,
  output logic [1:0]        cmpl_status
);
  walk_st_e st_q, st_d;
  logic     cmpl_q, cmpl_d;
  cmpl_e    stat_q, stat_d;
  logic     chk_ok, chk_zero, chk_region;
  logic     load_en, step_en, last_blk;
  logic     accept;

  erase_geom_check #(
    .ADDR_W(ADDR_W), .R0_BLK(R0_BLK), .R0_CNT(R0_CNT),
    .R1_BLK(R1_BLK), .R1_CNT(R1_CNT)
  ) u_check (
    .start_i       (req_start),
    .len_i         (req_len),
    .ok_o          (chk_ok),
    .zero_o        (chk_zero),
    .start_region_o(chk_region)
  );

  erase_addr_walker #(
    .ADDR_W(ADDR_W), .R0_BLK(R0_BLK), .R0_CNT(R0_CNT), .R1_BLK(R1_BLK)
  ) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (st_q == WALK_BUSY),
    .load_en_i    (load_en),
    .load_addr_i  (req_start),
    .load_len_i   (req_len),
    .load_region_i(chk_region),
    .step_en_i    (step_en),
    .addr_o       (erase_addr),
    .last_o       (last_blk)
  );

  always_comb begin
    accept  = (st_q == WALK_IDLE) && req_valid;
    st_d    = st_q;
    cmpl_d  = 1'b0;
    stat_d  = stat_q;
    load_en = 1'b0;
    step_en = 1'b0;
    unique case (st_q)
      WALK_IDLE: begin
        if (accept) begin
          if (!chk_ok) begin
            cmpl_d = 1'b1;
            stat_d = CMPL_INVAL;
          end else if (chk_zero) begin
            cmpl_d = 1'b1;
            stat_d = CMPL_OK;
          end else begin
            load_en = 1'b1;
            st_d    = WALK_BUSY;
          end
        end
      end
      WALK_BUSY: begin
        if (erase_ack) begin
          if (erase_fail) begin
            st_d   = WALK_IDLE;
            cmpl_d = 1'b1;
            stat_d = CMPL_IO;
          end else begin
            step_en = 1'b1;
            if (last_blk) begin
              st_d   = WALK_IDLE;
              cmpl_d = 1'b1;
              stat_d = CMPL_OK;
            end
          end
        end
      end
      default: st_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WALK_IDLE;
      cmpl_q <= 1'b0;
      stat_q <= CMPL_OK;
    end else begin
      st_q   <= st_d;
      cmpl_q <= cmpl_d;
      if (cmpl_d) stat_q <= stat_d;
    end
  end

  assign req_ready   = (st_q == WALK_IDLE);
  assign erase_req   = (st_q == WALK_BUSY);
  assign cmpl_valid  = cmpl_q;
  assign cmpl_status = stat_q;

  // R5: one outstanding block, address held until acknowledged
  p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && !erase_ack |=> erase_req && $stable(erase_addr));

  // R7: a failing block stops the walk and reports an I/O failure
  p_fail_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && erase_ack && erase_fail |=> !erase_req && cmpl_valid && (cmpl_status == 2'd2));

  // R1: a rejected request never starts erasing
  p_inval_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_valid && !chk_ok |=> !erase_req && cmpl_valid && (cmpl_status == 2'd1));

  // R4: an empty valid request completes without an erase
  p_zero_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_valid && chk_ok && chk_zero |=> !erase_req && cmpl_valid && (cmpl_status == 2'd0));

  // R10: completion is a single-cycle pulse with a defined code
  p_cmpl_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |=> !cmpl_valid);

  p_cmpl_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |-> (cmpl_status != 2'd3));
endmodule

// File: tb/sim_erase_range_walker.sv
`timescale 1ns/1ps
module sim_erase_range_walker;
  localparam int ADDR_W = 24;
  localparam int SBLK   = 'h4000;
  localparam int LBLK   = 'h20000;
  localparam int BOUND  = 'h20000;
  localparam int TOTAL  = 'h400000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_start = '0;
  logic [ADDR_W-1:0] req_len = '0;
  logic              req_ready;
  logic              erase_req;
  logic [ADDR_W-1:0] erase_addr;
  logic              erase_ack = 1'b0;
  logic              erase_fail = 1'b0;
  logic              cmpl_valid;
  logic [1:0]        cmpl_status;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  erase_range_walker #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_start(req_start),
    .req_len(req_len), .req_ready(req_ready), .erase_req(erase_req),
    .erase_addr(erase_addr), .erase_ack(erase_ack), .erase_fail(erase_fail),
    .cmpl_valid(cmpl_valid), .cmpl_status(cmpl_status)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model, updated on each rising edge
  bit m_busy = 0;
  int m_addr = 0;
  int m_rem  = 0;
  bit m_cmpl = 0;
  int m_stat = 0;
  bit m_live = 0;

  always @(posedge clk) begin
    int e;
    int step;
    if (!rst_n) begin
      m_busy = 0; m_cmpl = 0; m_live = 0;
    end else begin
      m_live = 1;
      m_cmpl = 0;
      if (!m_busy) begin
        if (req_valid) begin
          e = int'(req_start) + int'(req_len);
          if (e > TOTAL ||
              (int'(req_start) % ((int'(req_start) >= BOUND) ? LBLK : SBLK)) != 0 ||
              (e % ((e >= BOUND) ? LBLK : SBLK)) != 0) begin
            m_cmpl = 1; m_stat = 1;
          end else if (req_len == 0) begin
            m_cmpl = 1; m_stat = 0;
          end else begin
            m_busy = 1; m_addr = int'(req_start); m_rem = int'(req_len);
          end
        end
      end else if (erase_ack) begin
        if (erase_fail) begin
          m_busy = 0; m_cmpl = 1; m_stat = 2;
        end else begin
          step = (m_addr < BOUND) ? SBLK : LBLK;
          m_addr += step;
          m_rem  -= step;
          if (m_rem <= 0) begin
            m_busy = 0; m_cmpl = 1; m_stat = 0;
          end
        end
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (m_live && rst_n && !done_flag) begin
      chk(req_ready == !m_busy, "R9", "req_ready", req_ready, !m_busy);
      chk(erase_req == m_busy, "R5", "erase_req", erase_req, m_busy);
      if (m_busy)
        chk(int'(erase_addr) == m_addr, "R6", "erase_addr", erase_addr, m_addr);
      chk(cmpl_valid == m_cmpl, "R10", "cmpl_valid", cmpl_valid, m_cmpl);
      if (m_cmpl)
        chk(int'(cmpl_status) == m_stat, "R10", "cmpl_status", cmpl_status, m_stat);
    end
  end

  // sequencer stand-in with programmable latency and failure injection
  int ack_delay = 0;
  int ack_cnt   = 0;
  int fail_addr = -1;
  int n_issued  = 0;

  always @(negedge clk) begin
    if (erase_ack) begin
      erase_ack  = 1'b0;
      erase_fail = 1'b0;
      ack_cnt    = 0;
    end else if (erase_req && rst_n) begin
      if (ack_cnt >= ack_delay) begin
        erase_ack  = 1'b1;
        erase_fail = (int'(erase_addr) == fail_addr);
        n_issued++;
      end else begin
        ack_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_flag) begin
      done_flag = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_req(input int start, input int len, input int exp_st,
                         input int exp_n, input string tag, input bit poke);
    bit seen;
    seen = 0;
    while (!req_ready) @(negedge clk);
    n_issued  = 0;
    req_valid = 1'b1;
    req_start = ADDR_W'(start);
    req_len   = ADDR_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      req_valid = 1'b0;
      if (poke && k == 3) begin
        req_valid = 1'b1;
        req_start = '0;
        req_len   = ADDR_W'(SBLK);
      end
      if (cmpl_valid) begin
        seen = 1;
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(seen, tag, "completion seen", seen, 1);
    chk(int'(cmpl_status) == exp_st, tag, "final status", cmpl_status, exp_st);
    chk(n_issued == exp_n, tag, "blocks issued", n_issued, exp_n);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(req_ready == 1'b1, "R11", "req_ready in reset", req_ready, 1);
    chk(erase_req == 1'b0, "R11", "erase_req in reset", erase_req, 0);
    chk(cmpl_valid == 1'b0, "R11", "cmpl_valid in reset", cmpl_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: empty request
    run_req(0, 0, 0, 0, "R4", 0);
    // R8: single, then several small blocks
    ack_delay = 2;
    run_req('h4000, 'h4000, 0, 1, "R8", 0);
    ack_delay = 0;
    run_req('h8000, 'hC000, 0, 3, "R8", 0);
    // R6: walk that crosses into the large region
    ack_delay = 1;
    run_req('h18000, 'h48000, 0, 4, "R6", 0);
    // R3: end exactly on region boundary counts as large region, aligned
    ack_delay = 3;
    run_req('h10000, 'h10000, 0, 4, "R3", 0);
    // R8: small-region walk ending inside small region
    ack_delay = 0;
    run_req(0, 'h1C000, 0, 7, "R8", 0);
    // R1: last large block exactly to device end, then past it
    run_req('h3E0000, 'h20000, 0, 1, "R1", 0);
    run_req('h3E0000, 'h40000, 1, 0, "R1", 0);
    // R2: start aligned for small blocks but in large region
    run_req('h24000, 'h1C000, 1, 0, "R2", 0);
    run_req('h24000, 0, 1, 0, "R2", 0);
    // R3: end in large region not on a large boundary
    run_req(0, 'h24000, 1, 0, "R3", 0);
    // R7: second block fails
    fail_addr = 'h40000;
    ack_delay = 1;
    run_req('h20000, 'h60000, 2, 2, "R7", 0);
    fail_addr = -1;
    // R9: request raised while busy is ignored
    ack_delay = 2;
    run_req('h18000, 'h48000, 0, 4, "R9", 1);

    repeat (3) @(negedge clk);
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule